// File: doc/BRIEF.md
# Program Counter with Return Stack

This block holds the fetch address of a small processor and computes a new one every clock cycle. A 4-bit control code from the decoder picks the update. The PC can step to the next address, hold, move by a signed 10-bit offset, or load an absolute address from the register file. It can also take a relative branch that depends on the ALU flag being set or clear. The register output feeds the program memory address directly.

Subroutine support sits inside the block as a small LIFO of return addresses. Both call forms save the address that follows the call before they jump. The return form restores the saved address. The LIFO holds two entries by default. When it overflows, the oldest entry is lost. When it underflows, it does not fault; it returns the value left in its bottom slot.

Top module: `pc_unit`

## Requirements
- R1: A low `rst_n` sampled at a rising clock edge sets the PC to 0, empties the return stack and clears both of its slots.
- R2: Code 0 (step) sets PC to PC+1. Wrapping is modulo 2^16, so 0xFFFF steps to 0x0000.
- R3: Code 1 (relative jump) sets PC to PC plus the 10-bit immediate, with immediate bit 9 as the sign, modulo 2^16.
- R4: Code 2 (hold) keeps the PC unchanged. Codes 9 through 15 behave exactly like hold and leave the stack untouched.
- R5: Code 3 (absolute jump) loads the PC from the 16-bit register-file input.
- R6: Code 4 (relative call) pushes PC+1 onto the return stack and applies the relative jump of R3.
- R7: Code 5 (absolute call) pushes PC+1 onto the return stack and loads the PC from the register-file input.
- R8: Code 6 (return) loads the PC with the top stack entry and removes that entry. Entries come back in last-in, first-out order.
- R9: Code 7 takes the relative jump when `flag_i` is 1 and otherwise steps. Code 8 takes the relative jump when `flag_i` is 0 and otherwise steps.
- R10: The stack holds two return addresses. A push onto a full stack keeps the two newest and drops the oldest.
- R11: A return on an empty stack loads the value last stored in the bottom slot, which is 0 after reset, and the stack stays empty.
- R12: Every PC update takes effect at the rising clock edge at which the code is sampled, and the new PC appears on `pc_o` after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| op_i | input | 4 | Update code (see R2 to R9) |
| imm_i | input | 10 | Signed branch offset |
| rf_i | input | 16 | Absolute target from register file |
| flag_i | input | 1 | ALU condition flag |
| pc_o | output | 16 | Current program address |

## Verification
The bench builds the block with its default values: a 16-bit PC, a 10-bit offset and a two-entry stack. With these values both wrap boundaries are easy to reach. Stepping from 0xFFFF and jumping backwards from 0x0000 each take only a couple of cycles. Nested calls three deep overflow the stack, and three returns then expose both the lost oldest entry and the underflow value from the bottom slot. A reference model in the bench follows the requirements and tracks the PC and both stack slots for every code. This includes the unused codes and both flag polarities of the conditional branches.

// File: rtl/pc_unit_pkg.sv
// Package: shared update codes and default sizes for the program counter.
// Assumes a 4-bit code field; codes not listed here are treated as hold.
package pc_unit_pkg;

    localparam int OP_W = 4;

    localparam logic [OP_W-1:0] OP_STEP    = 4'd0;
    localparam logic [OP_W-1:0] OP_JREL    = 4'd1;
    localparam logic [OP_W-1:0] OP_HOLD    = 4'd2;
    localparam logic [OP_W-1:0] OP_JABS    = 4'd3;
    localparam logic [OP_W-1:0] OP_CALLREL = 4'd4;
    localparam logic [OP_W-1:0] OP_CALLABS = 4'd5;
    localparam logic [OP_W-1:0] OP_RET     = 4'd6;
    localparam logic [OP_W-1:0] OP_BR_SET  = 4'd7;
    localparam logic [OP_W-1:0] OP_BR_CLR  = 4'd8;

    // Stack action requested by the next-address logic.
    typedef struct packed {
        logic push;
        logic pop;
    } stk_req_t;

endpackage

// File: rtl/pc_sext.sv
// Module: widens the signed branch offset to the PC width.
// Assumes two's complement; if the offset is wider than the PC it is truncated.
module pc_sext #(
    parameter int IMM_W = 10,
    parameter int PC_W  = 16
) (
    input  logic [IMM_W-1:0] imm_i,
    output logic [PC_W-1:0]  ext_o
);

    generate
        if (IMM_W < PC_W) begin : g_extend
            localparam int PAD_W = PC_W - IMM_W;
            // Replicate the sign bit into the upper bits.
            always_comb ext_o = {{PAD_W{imm_i[IMM_W-1]}}, imm_i};
        end else begin : g_trunc
            // Offset is at least as wide as the PC: keep the low bits.
            always_comb ext_o = imm_i[PC_W-1:0];
        end
    endgenerate

endmodule

// File: rtl/pc_ret_stack.sv
// Module: return-address LIFO with DEPTH slots, slot 0 being the top.
// Assumes push and pop are never requested together. A full push drops the
// deepest entry; an empty pop yields slot 0, which then mirrors the bottom slot.
module pc_ret_stack #(
    parameter int PC_W  = 16,
    parameter int DEPTH = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push_i,
    input  logic            pop_i,
    input  logic [PC_W-1:0] data_i,
    output logic [PC_W-1:0] top_o
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [PC_W-1:0]  slot_q [DEPTH];
    logic [CNT_W-1:0] cnt_q;
    logic             full;
    logic             empty;

    always_comb full  = (cnt_q == FULL_CNT);
    always_comb empty = (cnt_q == '0);
    always_comb top_o = slot_q[0];

    // Shift slots down on push, up on pop; the bottom slot keeps its value on pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
        end else if (push_i) begin
            slot_q[0] <= data_i;
            for (int i = 1; i < DEPTH; i++) slot_q[i] <= slot_q[i-1];
        end else if (pop_i) begin
            for (int i = 0; i < DEPTH - 1; i++) slot_q[i] <= slot_q[i+1];
        end
    end

    // Track occupancy, saturating at both ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (push_i && !full) begin
            cnt_q <= cnt_q + 1'b1;
        end else if (pop_i && !empty) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= FULL_CNT);                                             // R10
    AST_FULL_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push_i) |=> (full && slot_q[0] == $past(data_i)));     // R10
    AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop_i) |=> (empty && $stable(top_o)));                // R11
    AST_NO_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        !(push_i && pop_i));                                            // R8

endmodule

// File: rtl/pc_next_sel.sv
// Module: combinational next-address selection and stack requests.
// Assumes the offset is already sign-extended and the stack top is valid
// whenever a return is issued (otherwise the bottom-slot value is used).
module pc_next_sel
    import pc_unit_pkg::*;
#(
    parameter int PC_W = 16
) (
    input  logic [OP_W-1:0] op_i,
    input  logic [PC_W-1:0] pc_i,
    input  logic [PC_W-1:0] offs_i,
    input  logic [PC_W-1:0] rf_i,
    input  logic            flag_i,
    input  logic [PC_W-1:0] top_i,
    output logic [PC_W-1:0] next_o,
    output logic [PC_W-1:0] ret_addr_o,
    output stk_req_t        req_o
);

    logic [PC_W-1:0] seq_pc;
    logic [PC_W-1:0] rel_pc;

    // Both arithmetic paths wrap at the PC width.
    always_comb seq_pc = pc_i + PC_W'(1);
    always_comb rel_pc = pc_i + offs_i;
    always_comb ret_addr_o = seq_pc;

    // Select the next address and the stack action from the update code.
    always_comb begin
        next_o = pc_i;
        req_o  = '0;
        case (op_i)
            OP_STEP:    next_o = seq_pc;
            OP_JREL:    next_o = rel_pc;
            OP_HOLD:    next_o = pc_i;
            OP_JABS:    next_o = rf_i;
            OP_CALLREL: begin
                next_o     = rel_pc;
                req_o.push = 1'b1;
            end
            OP_CALLABS: begin
                next_o     = rf_i;
                req_o.push = 1'b1;
            end
            OP_RET: begin
                next_o    = top_i;
                req_o.pop = 1'b1;
            end
            OP_BR_SET:  next_o = flag_i ? rel_pc : seq_pc;
            OP_BR_CLR:  next_o = flag_i ? seq_pc : rel_pc;
            default:    next_o = pc_i;
        endcase
    end

endmodule

// File: rtl/pc_unit.sv
// Module: top of the program counter; registers the address and owns the
// return stack. Assumes one update code per cycle from the decoder.
module pc_unit
    import pc_unit_pkg::*;
#(
    parameter int PC_W  = 16,
    parameter int IMM_W = 10,
    parameter int DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       op_i,
    input  logic [IMM_W-1:0] imm_i,
    input  logic [PC_W-1:0]  rf_i,
    input  logic             flag_i,
    output logic [PC_W-1:0]  pc_o
);

    logic [PC_W-1:0] pc_q;
    logic [PC_W-1:0] pc_d;
    logic [PC_W-1:0] offs;
    logic [PC_W-1:0] ret_addr;
    logic [PC_W-1:0] stk_top;
    stk_req_t        req;

    pc_sext #(.IMM_W(IMM_W), .PC_W(PC_W)) u_sext (
        .imm_i (imm_i),
        .ext_o (offs)
    );

    pc_next_sel #(.PC_W(PC_W)) u_next (
        .op_i       (op_i),
        .pc_i       (pc_q),
        .offs_i     (offs),
        .rf_i       (rf_i),
        .flag_i     (flag_i),
        .top_i      (stk_top),
        .next_o     (pc_d),
        .ret_addr_o (ret_addr),
        .req_o      (req)
    );

    pc_ret_stack #(.PC_W(PC_W), .DEPTH(DEPTH)) u_stack (
        .clk    (clk),
        .rst_n  (rst_n),
        .push_i (req.push),
        .pop_i  (req.pop),
        .data_i (ret_addr),
        .top_o  (stk_top)
    );

    // Program address register, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_d;
    end

    always_comb pc_o = pc_q;

    AST_RESET_ZERO: assert property (@(posedge clk)
        !rst_n |=> pc_o == '0);                                          // R1
    AST_STEP_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_STEP) |=> pc_o == $past(pc_o) + PC_W'(1));           // R2
    AST_HOLD_SAME: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_HOLD || op_i > OP_BR_CLR) |=> $stable(pc_o));        // R4
    AST_ABS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_JABS) |=> pc_o == $past(rf_i));                      // R5
    AST_CALL_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_CALLREL || op_i == OP_CALLABS)
        |=> stk_top == $past(pc_o) + PC_W'(1));                          // R6
    AST_RET_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_RET) |=> pc_o == $past(stk_top));                    // R8

endmodule

// File: tb/pc_unit_tb.sv
// Directed bench with a requirement-level reference model of PC and stack.
module pc_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_i = 4'd2;
    logic [9:0]  imm_i = '0;
    logic [15:0] rf_i = '0;
    logic        flag_i = 1'b0;
    logic [15:0] pc_o;

    int checks = 0;
    int errors = 0;

    logic [15:0] m_pc;
    logic [15:0] m_s0, m_s1;
    int          m_cnt;

    always #5 clk = ~clk;

    pc_unit u_dut (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .imm_i(imm_i),
        .rf_i(rf_i), .flag_i(flag_i), .pc_o(pc_o)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: pc actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] sx(input logic [9:0] v);
        return {{6{v[9]}}, v};
    endfunction

    // Reference model of one update, written from the requirements.
    task automatic model(input logic [3:0] op, input logic [9:0] imm,
                         input logic [15:0] rf, input logic fl);
        logic [15:0] nxt;
        nxt = m_pc;
        case (op)
            4'd0: nxt = m_pc + 16'd1;
            4'd1: nxt = m_pc + sx(imm);
            4'd3: nxt = rf;
            4'd4, 4'd5: begin
                nxt = (op == 4'd4) ? m_pc + sx(imm) : rf;
                m_s1 = m_s0;
                m_s0 = m_pc + 16'd1;
                if (m_cnt < 2) m_cnt++;
            end
            4'd6: begin
                nxt = m_s0;
                m_s0 = m_s1;
                if (m_cnt > 0) m_cnt--;
            end
            4'd7: nxt = fl ? m_pc + sx(imm) : m_pc + 16'd1;
            4'd8: nxt = fl ? m_pc + 16'd1 : m_pc + sx(imm);
            default: nxt = m_pc;
        endcase
        m_pc = nxt;
    endtask

    // Apply one code for one cycle and compare the PC after the edge (R12).
    task automatic apply(input logic [3:0] op, input logic [9:0] imm,
                         input logic [15:0] rf, input logic fl, input string req);
        @(negedge clk);
        op_i = op; imm_i = imm; rf_i = rf; flag_i = fl;
        model(op, imm, rf, fl);
        @(posedge clk);
        #1;
        check(req, pc_o, m_pc);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; op_i = 4'd0;
        @(posedge clk); @(posedge clk);
        #1;
        m_pc = '0; m_s0 = '0; m_s1 = '0; m_cnt = 0;
        check("R1", pc_o, 16'h0000);
        @(negedge clk);
        rst_n = 1'b1; op_i = 4'd2;
    endtask

    task automatic t_step_wrap();
        apply(4'd0, '0, '0, 1'b0, "R2");
        apply(4'd0, '0, '0, 1'b0, "R2");
        apply(4'd3, '0, 16'hFFFE, 1'b0, "R5");
        apply(4'd0, '0, '0, 1'b0, "R2");
        apply(4'd0, '0, '0, 1'b0, "R2");
        check("R2 wrap", pc_o, 16'h0000);
    endtask

    task automatic t_rel_jump();
        apply(4'd1, 10'd100, '0, 1'b0, "R3");
        apply(4'd1, 10'h3FF, '0, 1'b0, "R3");
        apply(4'd1, 10'h200, '0, 1'b0, "R3");
        check("R3 neg wrap", pc_o, 16'd99 - 16'd512);
        apply(4'd1, 10'h1FF, '0, 1'b0, "R3");
    endtask

    task automatic t_hold_unused();
        apply(4'd2, 10'd5, 16'h1234, 1'b1, "R4");
        for (int c = 9; c < 16; c++) apply(4'(c), 10'd7, 16'hBEEF, 1'b1, "R4");
        apply(4'd3, '0, 16'hA5A5, 1'b0, "R5");
    endtask

    task automatic t_cond();
        apply(4'd7, 10'd16, '0, 1'b1, "R9 set taken");
        apply(4'd7, 10'd16, '0, 1'b0, "R9 set not taken");
        apply(4'd8, 10'h3F0, '0, 1'b0, "R9 clr taken");
        apply(4'd8, 10'h3F0, '0, 1'b1, "R9 clr not taken");
    endtask

    task automatic t_call_ret();
        apply(4'd3, '0, 16'h1000, 1'b0, "R5");
        apply(4'd4, 10'd32, '0, 1'b0, "R6");
        apply(4'd5, '0, 16'h2000, 1'b0, "R7");
        apply(4'd6, '0, '0, 1'b0, "R8");
        check("R8 inner", pc_o, 16'h1021);
        apply(4'd6, '0, '0, 1'b0, "R8");
        check("R8 outer", pc_o, 16'h1001);
    endtask

    task automatic t_overflow_underflow();
        apply(4'd3, '0, 16'h0400, 1'b0, "R5");
        apply(4'd5, '0, 16'h0500, 1'b0, "R7");
        apply(4'd5, '0, 16'h0600, 1'b0, "R7");
        apply(4'd5, '0, 16'h0700, 1'b0, "R10");
        apply(4'd6, '0, '0, 1'b0, "R10");
        check("R10 newest", pc_o, 16'h0601);
        apply(4'd6, '0, '0, 1'b0, "R10");
        check("R10 second", pc_o, 16'h0501);
        apply(4'd6, '0, '0, 1'b0, "R11");
        check("R11 bottom", pc_o, 16'h0501);
        apply(4'd4, 10'd2, '0, 1'b0, "R6");
        apply(4'd6, '0, '0, 1'b0, "R8");
    endtask

    task automatic t_empty_after_reset();
        do_reset();
        apply(4'd6, '0, '0, 1'b0, "R11");
        check("R11 reset bottom", pc_o, 16'h0000);
    endtask

    initial begin
        m_pc = '0; m_s0 = '0; m_s1 = '0; m_cnt = 0;
        do_reset();
        t_step_wrap();
        t_rel_jump();
        t_hold_unused();
        t_cond();
        t_call_ret();
        t_overflow_underflow();
        t_empty_after_reset();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule